// File: doc/BRIEF.md
# Triggered Decimating Snapshot Capture Buffer

This block records a short window of four 12-bit sample streams once an event occurs. The streams are two mixer outputs (in-phase and quadrature) and two oscillator outputs (sine and cosine). Software first arms the buffer and chooses which of four event lines starts a capture. It also sets how many input samples are skipped between the samples that are kept, and how many kept sample slots pass before storing begins. The sine and cosine samples reach the block already aligned with the mixer outputs.

When the selected event line is seen high while the buffer is armed, the block starts counting. It counts retained sample slots at the decimated rate. It lets the programmed delay elapse, then writes 64 consecutive retained samples of every channel into internal storage and raises a done flag.

The stored words are read back through a register-style port. The read port has a single address input and returns data one clock later. Each stored word is sign-extended to 16 bits. Addresses outside the capture window read as zero. The port has no write path, so the stored data can only be read.

Top module: `snap_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `done` is 0, `rd_data` is 0 and the buffer is not armed, so event lines are ignored until `arm` is pulsed.
- R2: A capture starts only while the buffer is armed, and only from the event line that `trig_sel` picks out of `trig_in`. The mapping is: 0 selects bit 0 (input sync), 1 selects bit 1 (delayed sync), 2 selects bit 2 (sync counter terminal count) and 3 selects bit 3 (snap sync). The unselected bits have no effect.
- R3: `rate_sel` is sampled at the event edge and keeps one sample in every N = `rate_sel`+1. The first retained slot is the sample present in the clock cycle that follows the event edge. Retained slot r is the sample r·N cycles later.
- R4: `start_dly` is sampled at the event edge and gives D retained slots that are skipped before storing. Values above 256 are treated as 256. Stored word j of each channel is the sample of retained slot D+j.
- R5: Each capture stores 64 words for each channel. `done` rises on the clock edge that writes word 63, which is the edge (D+63)·N+1 cycles after the event edge. `done` then stays high until the next `arm`.
- R6: While a capture is running, and after it completes, event lines are ignored until the next `arm`.
- R7: `rd_data` holds, one clock after `rd_addr` is presented, the stored word at that address. Addresses 256–319 hold in-phase words 0–63, 320–383 hold quadrature words, 384–447 hold sine words and 448–511 hold cosine words.
- R8: Each 12-bit stored word is returned with bit 11 copied into bits 15:12.
- R9: A read from any address below 256 or above 511 returns 0.
- R10: `arm` has priority over everything else. It clears `done`, abandons any capture in progress and re-arms the buffer, so a new event starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | Arm pulse, clears done |
| trig_in | input | 4 | Event lines: input sync, delayed sync, terminal count, snap sync |
| trig_sel | input | 2 | Index of the event line that starts a capture |
| rate_sel | input | 2 | Decimation: keep one sample in rate_sel+1 |
| start_dly | input | 9 | Retained slots skipped before storing (saturates at 256) |
| si | input | 12 | In-phase mixer sample |
| sq | input | 12 | Quadrature mixer sample |
| asin | input | 12 | Oscillator sine sample |
| acos | input | 12 | Oscillator cosine sample |
| rd_addr | input | 10 | Read address |
| rd_data | output | 16 | Sign-extended read data, one clock after address |
| done | output | 1 | Capture complete |

## Verification
The bench uses the default parameters: 64-word depth, a 256-slot delay limit, a window at address 256 and a 10-bit address. The small delay limit lets a capture at the largest decimation with a saturated delay finish in about 1300 cycles. The 10-bit address reaches reads both below and above the window. A behavioural model computes each stored word from the sample index, not from counters. It is compared with `done` and `rd_data` on every clock, across all four decimation settings, all four event lines, zero and saturated delays, and a re-arm in the middle of a capture.

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int SW      = 12,
  parameter int RW      = 16,
  parameter int DEPTH   = 64,
  parameter int AW      = 10,
  parameter int BASE    = 256,
  parameter int DLY_MAX = 256,
  parameter int NTRIG   = 4,
  parameter int RATES   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             arm,
  input  logic [NTRIG-1:0]                 trig_in,
  input  logic [$clog2(NTRIG)-1:0]         trig_sel,
  input  logic [$clog2(RATES)-1:0]         rate_sel,
  input  logic [$clog2(DLY_MAX+1)-1:0]     start_dly,
  input  logic [SW-1:0]                    si,
  input  logic [SW-1:0]                    sq,
  input  logic [SW-1:0]                    asin,
  input  logic [SW-1:0]                    acos,
  input  logic [AW-1:0]                    rd_addr,
  output logic [RW-1:0]                    rd_data,
  output logic                             done
);
  localparam int IW  = $clog2(DEPTH);
  localparam int DW  = $clog2(DLY_MAX+1);
  localparam int RSW = $clog2(RATES);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + 4*DEPTH - 1);

  logic           armed, busy;
  logic [RSW-1:0] ph, rate_q;
  logic [DW-1:0]  skip;
  logic [IW-1:0]  idx;
  logic [SW-1:0]  mem [4][DEPTH];

  logic          fire, tick, wr, hit;
  logic [DW-1:0] dly_sat;
  logic [IW+1:0] loc;
  logic [SW-1:0] word;
  logic [SW-1:0] din [4];

  assign fire    = armed & trig_in[trig_sel];
  assign tick    = busy & (ph == '0);
  assign wr      = tick & (skip == '0);
  assign dly_sat = (start_dly > DW'(DLY_MAX)) ? DW'(DLY_MAX) : start_dly;
  assign hit     = (rd_addr >= LO) && (rd_addr <= HI);
  assign loc     = (IW+2)'(rd_addr - LO);
  assign word    = mem[loc[IW+1:IW]][loc[IW-1:0]];
  assign din[0]  = si;
  assign din[1]  = sq;
  assign din[2]  = asin;
  assign din[3]  = acos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      ph     <= '0;
      rate_q <= '0;
      skip   <= '0;
      idx    <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (fire) begin
      armed  <= 1'b0;
      busy   <= 1'b1;
      ph     <= '0;
      rate_q <= rate_sel;
      skip   <= dly_sat;
      idx    <= '0;
    end else if (busy) begin
      ph <= (ph == rate_q) ? '0 : ph + 1'b1;
      if (tick) begin
        if (skip != '0) begin
          skip <= skip - 1'b1;
        end else begin
          idx <= idx + 1'b1;
          if (idx == IW'(DEPTH-1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int c = 0; c < 4; c++) mem[c][idx] <= din[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_data <= '0;
    else if (hit) rd_data <= {{(RW-SW){word[SW-1]}}, word};
    else          rd_data <= '0;
  end
endmodule

module snap_capture_chk #(
  parameter int SW    = 12,
  parameter int RW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 10,
  parameter int BASE  = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          busy,
  input logic [AW-1:0] rd_addr,
  input logic [RW-1:0] rd_data,
  input logic          done
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + 4*DEPTH - 1);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!done && rd_data == '0));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  p_arm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && !busy));

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < LO || rd_addr > HI) |=> (rd_data == '0));

  p_sign_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&rd_data[RW-1:SW-1]) || (rd_data[RW-1:SW-1] == '0)));
endmodule

bind snap_capture snap_capture_chk #(
  .SW(SW), .RW(RW), .DEPTH(DEPTH), .AW(AW), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy),
  .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
);

// File: tb/sim_snap_capture.sv
`timescale 1ns/1ps
module sim_snap_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [3:0]  trig_in = '0;
  logic [1:0]  trig_sel = '0;
  logic [1:0]  rate_sel = '0;
  logic [8:0]  start_dly = '0;
  logic [11:0] si = '0, sq = '0, asin = '0, acos = '0;
  logic [9:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        done;

  always #4 clk = ~clk;

  snap_capture u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_in(trig_in), .trig_sel(trig_sel),
    .rate_sel(rate_sel), .start_dly(start_dly), .si(si), .sq(sq), .asin(asin),
    .acos(acos), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  int checks = 0, failures = 0;
  string cur_tag = "R7";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    si   <= 12'(cyc * 37 + 5);
    sq   <= 12'(cyc * 91) ^ 12'hA5A;
    asin <= 12'(cyc * 13 + 2048);
    acos <= 12'(4095 - cyc * 3);
  end

  int  mm [4][64];
  bit  mv [4][64];
  bit  m_armed = 0, m_busy = 0, m_done = 0;
  int  m_k, m_n, m_d;
  logic [15:0] exp_rd = '0;
  bit  rd_known = 1, started = 0;

  always @(posedge clk) begin
    int a, c, i, v, j;
    started = 1;
    a = int'(rd_addr);
    if (!rst_n) begin exp_rd = '0; rd_known = 1; end
    else if (a >= 256 && a < 512) begin
      c = (a - 256) / 64; i = (a - 256) % 64;
      rd_known = mv[c][i]; v = mm[c][i];
      if (v >= 2048) v -= 4096;
      exp_rd = 16'(v);
    end else begin exp_rd = '0; rd_known = 1; end

    if (!rst_n) begin m_armed = 0; m_busy = 0; m_done = 0; end
    else if (arm) begin m_armed = 1; m_busy = 0; m_done = 0; end
    else if (m_armed && trig_in[trig_sel]) begin
      m_armed = 0; m_busy = 1; m_k = 0;
      m_n = int'(rate_sel) + 1;
      m_d = (int'(start_dly) > 256) ? 256 : int'(start_dly);
    end else if (m_busy) begin
      if (m_k % m_n == 0 && m_k / m_n >= m_d) begin
        j = m_k / m_n - m_d;
        mm[0][j] = int'(si); mm[1][j] = int'(sq);
        mm[2][j] = int'(asin); mm[3][j] = int'(acos);
        for (int q = 0; q < 4; q++) mv[q][j] = 1;
        if (j == 63) begin m_busy = 0; m_done = 1; end
      end
      m_k++;
    end
  end

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk(done === m_done, "R5 done flag", int'(done), int'(m_done));
      if (rd_known) chk(rd_data === exp_rd, cur_tag, int'(rd_data), int'(exp_rd));
    end
  end

  task automatic sweep(input string tag);
    cur_tag = tag;
    for (int a = 256; a < 512; a++) begin
      rd_addr = 10'(a);
      @(negedge clk);
      chk((&rd_data[15:11]) || (rd_data[15:11] == '0), "R8 sign extension", int'(rd_data), 0);
    end
    foreach (oob[k]) begin
      rd_addr = oob[k];
      @(negedge clk);
      chk(rd_data == '0, "R9 outside window", int'(rd_data), 0);
    end
    rd_addr = '0;
    cur_tag = "R7";
  endtask

  logic [9:0] oob [4] = '{10'd0, 10'd255, 10'd512, 10'd1023};

  task automatic pulse_arm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic capture(input int sel, input int rate, input int dly, input string tag);
    int n, d, cnt;
    n = rate + 1; d = (dly > 256) ? 256 : dly;
    pulse_arm();
    trig_sel = 2'(sel); rate_sel = 2'(rate); start_dly = 9'(dly);
    trig_in = 4'(1 << ((sel + 1) % 4));
    @(negedge clk); trig_in = '0;
    repeat (70) @(negedge clk);
    chk(done == 1'b0, "R2 unselected line ignored", int'(done), 0);
    trig_in = 4'(1 << sel);
    cnt = 0;
    while (!done && cnt < 3000) begin
      @(negedge clk); cnt++;
      trig_in = (cnt == 9) ? 4'hF : '0;
      if (cnt == 1) rate_sel = 2'(3 - rate);
    end
    trig_in = '0;
    chk(cnt == 2 + (d + 63) * n, {tag, " done timing"}, cnt, 2 + (d + 63) * n);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R6 done held, retrigger ignored", int'(done), 1);
    sweep(tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(rd_data == '0, "R1 reset read", int'(rd_data), 0);
    trig_in = 4'hF;
    @(negedge clk); trig_in = '0;
    repeat (100) @(negedge clk);
    chk(done == 1'b0, "R1 R2 unarmed trigger ignored", int'(done), 0);

    capture(3, 0, 0, "R7");
    capture(1, 2, 5, "R3");
    capture(2, 3, 300, "R4");
    capture(0, 1, 256, "R4");

    pulse_arm();
    trig_sel = 2'd2; rate_sel = 2'd0; start_dly = 9'd0;
    trig_in = 4'b0100; @(negedge clk); trig_in = '0;
    repeat (20) @(negedge clk);
    pulse_arm();
    repeat (100) @(negedge clk);
    chk(done == 1'b0, "R10 rearm abandons capture", int'(done), 0);
    trig_in = 4'b0100; @(negedge clk); trig_in = '0;
    repeat (80) @(negedge clk);
    chk(done == 1'b1, "R10 fresh capture completes", int'(done), 1);
    sweep("R10");
    pulse_arm();
    chk(done == 1'b0, "R10 arm clears done", int'(done), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule